// File: doc/BRIEF.md
# Four-Wide Decode and Dispatch Stage

This stage sits between instruction fetch and the two issue queues of an out-of-order integer core. Each cycle it accepts up to four fetched instruction words into an eight-entry circular buffer. It gives every accepted word its program counter, using a not-taken prediction, so the fetch address simply advances past whatever was accepted. From the oldest end of the buffer it dispatches up to four instructions per cycle, in program order. Loads and stores go to the address queue. Every other instruction goes to the integer queue, including the register-indirect jumps, whose targets are only known once they have executed. Each dispatched instruction is also counted as one reorder-buffer insertion.

Dispatch stops at the first instruction that cannot leave. It cannot leave when its target queue has no free slot left this cycle, or when its destination register is still marked busy. It also cannot leave when an older instruction in the same group writes the same destination. A 32-entry busy-bit file is set as destinations are dispatched and cleared by execution write-back ports. When a mispredict is signalled, the stage dispatches nothing that cycle, empties the buffer, drops the incoming words and restarts fetch at the corrected address. Registers and addresses are 32 bits wide. There is no delay slot and there are no floating-point instructions.

Top module: `dd_dispatch`

## Requirements
- R1: The buffer holds at most 8 entries, and `in_ready` is high exactly when at least 4 entries are free. While `in_ready` is low, the words on `in_words` are ignored and `fetch_pc` does not move.
- R2: Accepted word k (bits [32k+31:32k] of `in_words`, k below `in_cnt`) gets PC `fetch_pc + 4k`. After the edge, `fetch_pc` has advanced by 4 times the number of words accepted. Reset loads `fetch_pc` with the RESET_PC parameter.
- R3: A word accepted at an edge can dispatch in the following cycle. Dispatch slot k carries the k-th oldest buffered instruction. Up to 4 dispatch per cycle, and `disp_valid` is always a contiguous run starting at slot 0.
- R4: Opcode bits [31:26] of the form 100xxx (load) or 101xxx (store) send the instruction to the address queue (`disp_aq`=1). All other opcodes go to the integer queue, including opcode 000000 with function bits [5:0] 001000 (register jump) or 001001 (register jump and link).
- R5: Instructions sent to the integer queue in one cycle never exceed `iq_free`, and instructions sent to the address queue never exceed `aq_free`. When the oldest remaining instruction cannot go, no younger one goes in that cycle.
- R6: The destination is bits [15:11] for opcode 000000 (none for the register jump). It is register 31 for opcode 000011, and bits [20:16] for opcodes 001xxx and 100xxx. Other opcodes and register 0 have no destination. An instruction does not dispatch while its destination is busy, or while an older instruction dispatching in the same cycle has the same destination.
- R7: The busy bit of a dispatched destination is set at the next edge. A write-back port (`wb_valid[p]`, register `wb_reg[5p+4:5p]`) clears its bit at the next edge. When a set and a clear hit the same bit at the same edge, the set wins. A write-back does not release a stalled instruction in the same cycle.
- R8: While `mispredict` is high, nothing dispatches and no word is accepted. After the edge the buffer is empty and `fetch_pc` equals `fix_pc`.
- R9: `rob_ins_cnt` equals the number of instructions dispatched in the cycle.
- R10: After reset the buffer is empty, `in_ready` is high, nothing dispatches and every busy bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_cnt | input | 3 | Number of fetched words offered (0 to 4) |
| in_words | input | 128 | Fetched words, slot k in bits [32k+31:32k] |
| in_ready | output | 1 | At least four buffer entries free |
| fetch_pc | output | 32 | Predicted address of the next fetch group |
| iq_free | input | 4 | Free slots in the integer queue |
| aq_free | input | 4 | Free slots in the address queue |
| wb_valid | input | 2 | Write-back valid per port |
| wb_reg | input | 10 | Write-back register per port, 5 bits each |
| mispredict | input | 1 | Branch resolved wrongly; flush and redirect |
| fix_pc | input | 32 | Corrected fetch address |
| disp_valid | output | 4 | Dispatch slot valid (also reorder-buffer insert) |
| disp_aq | output | 4 | Slot goes to the address queue |
| disp_pc | output | 128 | PC per dispatch slot |
| disp_word | output | 128 | Instruction word per dispatch slot |
| rob_ins_cnt | output | 3 | Reorder-buffer insertions this cycle |
| reg_busy | output | 32 | Busy bit per architectural register |

## Verification
A table of single instructions covers every opcode class: register, register jump, register jump and link, load, store, immediate, jump and link, branch, and a write to register 0. Each entry tells queue routing apart from destination extraction and from busy set and clear. Four-wide groups of independent register instructions show full width, correct per-slot PCs and the fetch-address step. Mixed groups under small queue counts separate per-queue limiting from the in-order stop. Groups with repeated destinations, combined with write-backs that land in the same cycle, separate the busy stall, the stall within a group and the rule that a set beats a clear. A full buffer and mispredicts with words offered show fetch being ignored, the flush and the redirect.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;
  localparam int unsigned RW   = 5;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] word;
  } slot_t;

  typedef struct packed {
    logic          vld;
    logic [RW-1:0] idx;
  } dst_t;

  // loads (100xxx) and stores (101xxx) use the address queue
  function automatic logic to_addr_q(input logic [XLEN-1:0] w);
    return (w[31:29] == 3'b100) || (w[31:29] == 3'b101);
  endfunction

  // register jump (001000) or register jump and link (001001)
  function automatic logic is_jump_reg(input logic [XLEN-1:0] w);
    return (w[31:26] == 6'b000000) && (w[5:1] == 5'b00100);
  endfunction

  function automatic dst_t dest_of(input logic [XLEN-1:0] w);
    dst_t d;
    d.vld = 1'b0;
    d.idx = '0;
    if (w[31:26] == 6'b000000) begin
      d.vld = (w[5:0] != 6'b001000);
      d.idx = w[15:11];
    end else if (w[31:26] == 6'b000011) begin
      d.vld = 1'b1;
      d.idx = 5'd31;
    end else if ((w[31:29] == 3'b001) || (w[31:29] == 3'b100)) begin
      d.vld = 1'b1;
      d.idx = w[20:16];
    end
    if (d.idx == '0) d.vld = 1'b0;
    return d;
  endfunction

  function automatic logic [XLEN-1:0] pc_plus_words(input logic [XLEN-1:0] pc,
                                                    input logic [XLEN-1:0] n);
    return pc + (n << 2);
  endfunction
endpackage

// File: rtl/dd_ibuf.sv
module dd_ibuf import dd_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int FW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(FW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [PW-1:0]      push_cnt,
  input  slot_t [FW-1:0]     push_slots,
  input  logic [PW-1:0]      pop_cnt,
  output slot_t [FW-1:0]     head_slots,
  output logic [FW-1:0]      head_vld,
  output logic [CW-1:0]      occ,
  output logic               room
);
  // DEPTH is a power of two so pointers wrap naturally
  slot_t           mem_q [DEPTH];
  logic [AW-1:0]   head_q;
  logic [CW-1:0]   occ_q;
  logic [AW-1:0]   tail;

  assign tail = head_q + AW'(occ_q);
  assign occ  = occ_q;
  assign room = (occ_q <= CW'(DEPTH - FW));

  for (genvar k = 0; k < FW; k++) begin : g_head
    assign head_slots[k] = mem_q[head_q + AW'(k)];
    assign head_vld[k]   = (occ_q > CW'(k));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_q + AW'(pop_cnt);
      occ_q  <= occ_q - CW'(pop_cnt) + CW'(push_cnt);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < FW; k++) begin
      if (!flush && (PW'(k) < push_cnt)) mem_q[tail + AW'(k)] <= push_slots[k];
    end
  end
endmodule

// File: rtl/dd_select.sv
module dd_select import dd_pkg::*; #(
  parameter int FW  = 4,
  parameter int QW  = 4,
  localparam int PW = $clog2(FW + 1)
) (
  input  slot_t [FW-1:0]   head_slots,
  input  logic [FW-1:0]    head_vld,
  input  logic             halt,
  input  logic [QW-1:0]    iq_free,
  input  logic [QW-1:0]    aq_free,
  input  logic [NREG-1:0]  busy,
  output logic [FW-1:0]    go,
  output logic [FW-1:0]    go_aq,
  output logic [PW-1:0]    go_cnt,
  output logic [NREG-1:0]  set_mask
);
  always_comb begin
    logic          stop;
    logic          mem;
    logic          ok;
    logic [QW-1:0] iq_used;
    logic [QW-1:0] aq_used;
    dst_t          d;
    stop     = halt;
    iq_used  = '0;
    aq_used  = '0;
    go       = '0;
    go_aq    = '0;
    go_cnt   = '0;
    set_mask = '0;
    for (int k = 0; k < FW; k++) begin
      d   = dest_of(head_slots[k].word);
      mem = to_addr_q(head_slots[k].word);
      ok  = head_vld[k] && !stop;
      if (mem) ok = ok && (aq_used < aq_free);
      else     ok = ok && (iq_used < iq_free);
      if (d.vld) ok = ok && !busy[d.idx] && !set_mask[d.idx];
      if (ok) begin
        go[k]    = 1'b1;
        go_aq[k] = mem;
        go_cnt   = go_cnt + PW'(1);
        if (mem) aq_used = aq_used + QW'(1);
        else     iq_used = iq_used + QW'(1);
        if (d.vld) set_mask[d.idx] = 1'b1;
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dd_busy.sv
module dd_busy import dd_pkg::*; #(
  parameter int NWB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   set_mask,
  input  logic [NWB-1:0]    wb_vld,
  input  logic [NWB*RW-1:0] wb_idx,
  output logic [NREG-1:0]   busy
);
  logic [NREG-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    for (int p = 0; p < NWB; p++) begin
      if (wb_vld[p]) clr_mask[wb_idx[p*RW +: RW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= (busy & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/dd_dispatch.sv
module dd_dispatch import dd_pkg::*; #(
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter int DEPTH = 8,
  parameter int FW    = 4,
  parameter int QW    = 4,
  parameter int NWB   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(FW+1)-1:0] in_cnt,
  input  logic [FW*32-1:0]        in_words,
  output logic                    in_ready,
  output logic [31:0]             fetch_pc,
  input  logic [QW-1:0]           iq_free,
  input  logic [QW-1:0]           aq_free,
  input  logic [NWB-1:0]          wb_valid,
  input  logic [NWB*5-1:0]        wb_reg,
  input  logic                    mispredict,
  input  logic [31:0]             fix_pc,
  output logic [FW-1:0]           disp_valid,
  output logic [FW-1:0]           disp_aq,
  output logic [FW*32-1:0]        disp_pc,
  output logic [FW*32-1:0]        disp_word,
  output logic [$clog2(FW+1)-1:0] rob_ins_cnt,
  output logic [31:0]             reg_busy
);
  localparam int PW = $clog2(FW + 1);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] clamp_take(input logic [PW-1:0] n);
    return (n > PW'(FW)) ? PW'(FW) : n;
  endfunction

  logic [PW-1:0]   take_cnt;
  logic            room_w;
  slot_t [FW-1:0]  push_slots;
  slot_t [FW-1:0]  head_slots;
  logic [FW-1:0]   head_vld;
  logic [FW-1:0]   go_w;
  logic [FW-1:0]   go_aq_w;
  logic [PW-1:0]   go_cnt_w;
  logic [CW-1:0]   occ_w;
  logic [NREG-1:0] set_mask_w;
  logic [NREG-1:0] busy_w;
  logic [31:0]     fetch_pc_q;

  // named events for the checker
  logic ev_flush;
  logic ev_take;
  assign ev_flush = mispredict;
  assign take_cnt = (room_w && !mispredict) ? clamp_take(in_cnt) : '0;
  assign ev_take  = (take_cnt != '0);

  for (genvar k = 0; k < FW; k++) begin : g_push
    assign push_slots[k].pc   = fetch_pc_q + 32'(4 * k);
    assign push_slots[k].word = in_words[k*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        fetch_pc_q <= RESET_PC;
    else if (ev_flush) fetch_pc_q <= fix_pc;
    else if (ev_take)  fetch_pc_q <= pc_plus_words(fetch_pc_q, 32'(take_cnt));
  end

  dd_ibuf #(.DEPTH(DEPTH), .FW(FW)) u_ibuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (ev_flush),
    .push_cnt   (take_cnt),
    .push_slots (push_slots),
    .pop_cnt    (go_cnt_w),
    .head_slots (head_slots),
    .head_vld   (head_vld),
    .occ        (occ_w),
    .room       (room_w)
  );

  dd_select #(.FW(FW), .QW(QW)) u_sel (
    .head_slots (head_slots),
    .head_vld   (head_vld),
    .halt       (ev_flush),
    .iq_free    (iq_free),
    .aq_free    (aq_free),
    .busy       (busy_w),
    .go         (go_w),
    .go_aq      (go_aq_w),
    .go_cnt     (go_cnt_w),
    .set_mask   (set_mask_w)
  );

  dd_busy #(.NWB(NWB)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask_w),
    .wb_vld   (wb_valid),
    .wb_idx   (wb_reg),
    .busy     (busy_w)
  );

  for (genvar k = 0; k < FW; k++) begin : g_out
    assign disp_pc[k*32 +: 32]   = head_slots[k].pc;
    assign disp_word[k*32 +: 32] = head_slots[k].word;
  end

  assign disp_valid  = go_w;
  assign disp_aq     = go_aq_w;
  assign rob_ins_cnt = go_cnt_w;
  assign reg_busy    = busy_w;
  assign in_ready    = room_w;
  assign fetch_pc    = fetch_pc_q;
endmodule

// File: rtl/dd_dispatch_chk.sv
module dd_dispatch_chk import dd_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int FW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_flush,
  input logic [31:0]   fix_pc,
  input logic [31:0]   fetch_pc,
  input logic [CW-1:0] occ,
  input logic [FW-1:0] disp_valid,
  input logic [FW-1:0] disp_aq,
  input logic [31:0]   word0,
  input logic [31:0]   reg_busy
);
  dst_t d0;
  assign d0 = dest_of(word0);

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_valid + FW'(1)) & disp_valid) == '0);

  p_jump_reg_iq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid[0] && is_jump_reg(word0)) |-> !disp_aq[0]);

  p_no_busy_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid[0] && d0.vld) |-> !reg_busy[d0.idx]);

  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid[0] && d0.vld) |=> reg_busy[$past(d0.idx)]);

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |-> (disp_valid == '0));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> (occ == '0));

  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> (fetch_pc == $past(fix_pc)));
endmodule

bind dd_dispatch dd_dispatch_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_flush   (ev_flush),
  .fix_pc     (fix_pc),
  .fetch_pc   (fetch_pc),
  .occ        (occ_w),
  .disp_valid (disp_valid),
  .disp_aq    (disp_aq),
  .word0      (disp_word[31:0]),
  .reg_busy   (reg_busy)
);

// File: tb/dd_dispatch_bench.sv
module dd_dispatch_bench;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   in_cnt;
  logic [127:0] in_words;
  logic         in_ready;
  logic [31:0]  fetch_pc;
  logic [3:0]   iq_free, aq_free;
  logic [1:0]   wb_valid;
  logic [9:0]   wb_reg;
  logic         mispredict;
  logic [31:0]  fix_pc;
  logic [3:0]   disp_valid, disp_aq;
  logic [127:0] disp_pc, disp_word;
  logic [2:0]   rob_ins_cnt;
  logic [31:0]  reg_busy;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_pc;

  always #10 clk = ~clk;

  dd_dispatch u_dd_dispatch (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_words(in_words),
    .in_ready(in_ready), .fetch_pc(fetch_pc), .iq_free(iq_free), .aq_free(aq_free),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .mispredict(mispredict), .fix_pc(fix_pc),
    .disp_valid(disp_valid), .disp_aq(disp_aq), .disp_pc(disp_pc),
    .disp_word(disp_word), .rob_ins_cnt(rob_ins_cnt), .reg_busy(reg_busy)
  );

  function automatic logic [31:0] rop(input logic [4:0] rd);
    return {6'b000000, 5'd1, 5'd2, rd, 5'd0, 6'b100001};
  endfunction
  function automatic logic [31:0] ldw(input logic [4:0] rt);
    return {6'b100011, 5'd1, rt, 16'h0010};
  endfunction

  // {word, to address queue, has destination, destination}
  localparam logic [38:0] TBL [9] = '{
    {6'b000000, 5'd1, 5'd2, 5'd3, 5'd0, 6'b100001, 1'b0, 1'b1, 5'd3},
    {6'b000000, 5'd4, 5'd0, 5'd0, 5'd0, 6'b001000, 1'b0, 1'b0, 5'd0},
    {6'b000000, 5'd4, 5'd0, 5'd9, 5'd0, 6'b001001, 1'b0, 1'b1, 5'd9},
    {6'b100011, 5'd1, 5'd6, 16'h0010,               1'b1, 1'b1, 5'd6},
    {6'b101011, 5'd1, 5'd6, 16'h0000,               1'b1, 1'b0, 5'd0},
    {6'b001001, 5'd2, 5'd12, 16'h0005,              1'b0, 1'b1, 5'd12},
    {6'b000011, 26'h0000010,                        1'b0, 1'b1, 5'd31},
    {6'b000100, 5'd1, 5'd2, 16'h0003,               1'b0, 1'b0, 5'd0},
    {6'b000000, 5'd1, 5'd2, 5'd0, 5'd0, 6'b100001,  1'b0, 1'b0, 5'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_cnt = '0; in_words = '0; wb_valid = '0; wb_reg = '0;
    mispredict = 1'b0; fix_pc = '0; iq_free = 4'd15; aq_free = 4'd15;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pc = RPC;
  endtask

  task automatic offer(input logic [2:0] n, input logic [31:0] w0, input logic [31:0] w1,
                       input logic [31:0] w2, input logic [31:0] w3);
    in_cnt = n;
    in_words = {w3, w2, w1, w0};
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    do_reset();
    #1;
    // R10 reset state
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R10 disp_valid", {28'd0, disp_valid}, 32'd0);
    chk("R10 reg_busy", reg_busy, 32'd0);
    chk("R2 reset fetch_pc", fetch_pc, RPC);

    // table walk: one instruction at a time (R4, R6, R7, R2)
    for (int i = 0; i < 9; i++) begin
      logic [31:0] w;
      logic        aq, hd;
      logic [4:0]  rd;
      {w, aq, hd, rd} = TBL[i];
      @(negedge clk);
      offer(3'd1, w, '0, '0, '0);
      @(negedge clk);
      in_cnt = '0;
      #1;
      chk("R3 table dispatch", {28'd0, disp_valid}, 32'd1);
      chk("R4 table queue", {31'd0, disp_aq[0]}, {31'd0, aq});
      chk("R2 table pc", disp_pc[31:0], exp_pc);
      chk("R3 table word", disp_word[31:0], w);
      chk("R9 table rob count", {29'd0, rob_ins_cnt}, 32'd1);
      exp_pc = exp_pc + 32'd4;
      @(negedge clk);
      #1;
      chk("R6 R7 table busy set", reg_busy, hd ? (32'd1 << rd) : 32'd0);
      wb_valid = {1'b0, hd};
      wb_reg = {5'd0, rd};
      @(negedge clk);
      wb_valid = '0;
      #1;
      chk("R7 table busy cleared", reg_busy, 32'd0);
    end
    chk("R2 table fetch_pc", fetch_pc, exp_pc);

    // four-wide group
    do_reset();
    offer(3'd4, rop(5'd1), rop(5'd2), rop(5'd3), rop(5'd4));
    #1;
    chk("R3 empty before accept", {28'd0, disp_valid}, 32'd0);
    @(negedge clk);
    in_cnt = '0;
    #1;
    chk("R3 four-wide valid", {28'd0, disp_valid}, 32'hF);
    chk("R9 four-wide rob count", {29'd0, rob_ins_cnt}, 32'd4);
    chk("R2 slot3 pc", disp_pc[127:96], RPC + 32'd12);
    chk("R2 fetch_pc step", fetch_pc, RPC + 32'd16);
    chk("R4 four-wide integer queue", {28'd0, disp_aq}, 32'd0);
    @(negedge clk);
    #1;
    chk("R7 four busy bits", reg_busy, 32'h0000_001E);

    // buffer fill, ignored fetch, integer queue limit
    do_reset();
    iq_free = 4'd0;
    offer(3'd4, rop(5'd1), rop(5'd2), rop(5'd3), rop(5'd4));
    @(negedge clk);
    #1;
    chk("R1 ready at four used", {31'd0, in_ready}, 32'd1);
    chk("R5 iq empty blocks", {28'd0, disp_valid}, 32'd0);
    offer(3'd4, rop(5'd5), rop(5'd6), rop(5'd7), rop(5'd8));
    @(negedge clk);
    offer(3'd4, rop(5'd20), rop(5'd21), rop(5'd22), rop(5'd23));
    #1;
    chk("R1 not ready when full", {31'd0, in_ready}, 32'd0);
    chk("R2 fetch_pc after eight", fetch_pc, RPC + 32'd32);
    @(negedge clk);
    in_cnt = '0;
    iq_free = 4'd2;
    #1;
    chk("R1 ignored fetch_pc", fetch_pc, RPC + 32'd32);
    chk("R5 iq limit two", {28'd0, disp_valid}, 32'h3);
    chk("R3 oldest first", disp_word[31:0], rop(5'd1));
    @(negedge clk);
    iq_free = 4'd15;
    #1;
    chk("R1 still not ready at six", {31'd0, in_ready}, 32'd0);
    chk("R3 next group valid", {28'd0, disp_valid}, 32'hF);
    chk("R2 next group pc", disp_pc[31:0], RPC + 32'd8);
    @(negedge clk);
    #1;
    chk("R1 ready again", {31'd0, in_ready}, 32'd1);
    chk("R1 ignored words absent", {28'd0, disp_valid}, 32'h3);
    chk("R2 tail pc", disp_pc[63:32], RPC + 32'd28);

    // address queue limit and in-order stop
    do_reset();
    aq_free = 4'd1;
    offer(3'd4, rop(5'd1), ldw(5'd6), ldw(5'd7), rop(5'd2));
    @(negedge clk);
    in_cnt = '0;
    #1;
    chk("R5 aq limit stops group", {28'd0, disp_valid}, 32'h3);
    chk("R4 mixed routing", {28'd0, disp_aq}, 32'h2);
    @(negedge clk);
    aq_free = 4'd15;
    #1;
    chk("R5 remainder", {28'd0, disp_valid}, 32'h3);
    chk("R4 remainder routing", {28'd0, disp_aq}, 32'h1);

    // busy stalls, write-back, set beats clear
    do_reset();
    offer(3'd4, rop(5'd5), rop(5'd5), rop(5'd6), rop(5'd7));
    @(negedge clk);
    in_cnt = '0;
    #1;
    chk("R6 same dest in group", {28'd0, disp_valid}, 32'h1);
    @(negedge clk);
    #1;
    chk("R6 busy dest stalls", {28'd0, disp_valid}, 32'h0);
    chk("R7 busy set r5", reg_busy, 32'h0000_0020);
    wb_valid = 2'b01;
    wb_reg = {5'd0, 5'd5};
    #1;
    chk("R7 no same-cycle release", {28'd0, disp_valid}, 32'h0);
    @(negedge clk);
    wb_valid = '0;
    #1;
    chk("R7 release after clear", {28'd0, disp_valid}, 32'h7);
    @(negedge clk);
    offer(3'd1, rop(5'd9), '0, '0, '0);
    #1;
    chk("R7 three busy", reg_busy, 32'h0000_00E0);
    @(negedge clk);
    in_cnt = '0;
    wb_valid = 2'b11;
    wb_reg = {5'd9, 5'd5};
    #1;
    chk("R6 r9 dispatches", {28'd0, disp_valid}, 32'h1);
    @(negedge clk);
    wb_valid = '0;
    #1;
    chk("R7 set beats clear", reg_busy, 32'h0000_02C0);

    // mispredict flush and redirect
    do_reset();
    iq_free = 4'd0;
    offer(3'd4, rop(5'd1), rop(5'd2), rop(5'd3), rop(5'd4));
    @(negedge clk);
    offer(3'd4, rop(5'd5), rop(5'd6), rop(5'd7), rop(5'd8));
    @(negedge clk);
    in_cnt = '0;
    iq_free = 4'd15;
    mispredict = 1'b1;
    fix_pc = 32'h0000_2000;
    #1;
    chk("R8 no dispatch on flush", {28'd0, disp_valid}, 32'h0);
    @(negedge clk);
    offer(3'd2, rop(5'd10), rop(5'd11), '0, '0);
    fix_pc = 32'h0000_3000;
    #1;
    chk("R8 redirect", fetch_pc, 32'h0000_2000);
    chk("R8 buffer emptied", {28'd0, disp_valid}, 32'h0);
    chk("R1 ready after flush", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    mispredict = 1'b0;
    offer(3'd1, rop(5'd3), '0, '0, '0);
    #1;
    chk("R8 offered words dropped", {28'd0, disp_valid}, 32'h0);
    chk("R8 second redirect", fetch_pc, 32'h0000_3000);
    @(negedge clk);
    in_cnt = '0;
    #1;
    chk("R2 pc after redirect", disp_pc[31:0], 32'h0000_3000);
    chk("R3 single after redirect", {28'd0, disp_valid}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule